// File: doc/BRIEF.md
# I2C Slave Register Port

This block is a two-wire serial slave. It lets an external bus master reach a bank of byte-wide control registers through a 16-bit internal pointer. The block samples the clock and data lines in the system clock domain and finds the START and STOP conditions. It matches a 7-bit device address and drives acknowledge bits on the open-drain data line. On the register side it works a simple synchronous memory port.

Every transfer begins with a device-address byte. In a write, the first two bytes after that byte load the pointer, high byte first. Each byte after those goes to the register at the pointer, and the pointer then steps by one. In a read, the data bytes follow the address byte at once. They start at the pointer left by the latest write and step the same way. A transfer can run to any length. A START or STOP at any bit drops a byte that is only partly shifted in.

The controller runs as one state machine. Its states are:
- `ST_IDLE`: waits for START.
- `ST_DEVADDR`: shifts in the address byte.
- `ST_PTRHI` and `ST_PTRLO`: take the two pointer bytes.
- `ST_WRDATA`: takes register data.
- `ST_ACK`: the slave-driven acknowledge slot. It returns to the state held in a follow-on register.
- `ST_RDDATA`: shifts out a register byte.
- `ST_RDACK`: samples the master's acknowledge.
- `ST_IGNORE`: stays silent after an address mismatch.

Its transitions are:
- START from any state leads to `ST_DEVADDR`.
- STOP from any state leads to `ST_IDLE`.
- `ST_DEVADDR` leads to `ST_ACK` on a match and to `ST_IGNORE` otherwise.
- `ST_PTRHI`, `ST_PTRLO` and `ST_WRDATA` lead to `ST_ACK` after eight bits.
- `ST_ACK` leads on to `ST_PTRHI`, `ST_PTRLO`, `ST_WRDATA` or `ST_RDDATA`.
- `ST_RDDATA` leads to `ST_RDACK` after eight bits.
- `ST_RDACK` leads to `ST_RDDATA` on an acknowledge and to `ST_IDLE` on a non-acknowledge.

Top module: `i2c_regport`

## Requirements
- R1: After reset the block does not drive the data line (`sda_oe` = 0), and it issues no register read or write strobe until a transfer addresses it.
- R2: The first byte after START is a 7-bit device address, MSB first, then a direction bit (0 = write, 1 = read). When the address equals `DEV_ADDR`, the block drives the data line low for the whole ninth clock pulse.
- R3: When the address does not match, the block sends no acknowledge. It drives nothing and touches no register for the rest of that transfer. It answers again only after the next START.
- R4: In a write, the two bytes after the address byte load the pointer, high byte first. Each later byte is written to the register at the pointer, and the pointer then steps by one. Every byte is acknowledged.
- R5: In a read, the bytes after the address byte are register contents sent MSB first, starting at the pointer. The pointer steps by one after each byte.
- R6: The pointer wraps from 0xFFFF to 0x0000, for both writes and reads.
- R7: A non-acknowledge from the master after a read byte ends the transfer. The block releases the data line and fetches no further register.
- R8: A START or STOP at any bit position drops a partly received byte. No write takes place and the pointer stays as it was.
- R9: A repeated START takes the place of a STOP, and a fresh address byte is expected. A read that follows it begins at the pointer loaded by the preceding write.
- R10: The block changes `sda_oe` only while the bus clock is low.
- R11: The number of bytes in one transfer is unlimited. A long burst writes and reads back every byte at consecutive addresses.
- R12: Each completed data byte produces exactly one write strobe or read strobe, one system clock wide, and the two are never active together. Read data is taken from `reg_rdata` one cycle after `reg_rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_addr | output | 16 | Register address for the current strobe |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd_en` |

## Verification
Directed bus transfers drive the block:
- A plain write burst, then a pointer load followed by a repeated START and a read. This separates a correct pointer hand-over from one that loses or shifts the pointer.
- A wrong device address followed by traffic. This shows whether the block keeps silent and leaves the registers untouched.
- Transfers cut by STOP or START in mid-byte. These show whether a partial byte leaks into a register or moves the pointer.
- Writes and reads across address 0xFFFF and a long burst. These show whether the pointer wraps correctly and whether length is unlimited.
- Ending each read with a non-acknowledge. This tells a clean release apart from one extra prefetch or a data line that is still held.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_PTRHI,
        ST_PTRLO,
        ST_WRDATA,
        ST_ACK,
        ST_RDDATA,
        ST_RDACK,
        ST_IGNORE
    } i2cr_state_e;

endpackage

// File: rtl/i2cr_sync.sv
// Multi-stage synchroniser for a group of asynchronous lines.
module i2cr_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= RST_VAL;
                else        chain_q[0] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RST_VAL;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/i2cr_linecond.sv
// Edge and bus-condition detection on the synchronised lines.
module i2cr_linecond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s && !scl_q;
    assign scl_fall  = !scl_s &&  scl_q;
    // data moving while the clock stays high marks a bus condition
    assign start_det =  scl_s &&  scl_q &&  sda_q && !sda_s;
    assign stop_det  =  scl_s &&  scl_q && !sda_q &&  sda_s;

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2cr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h4A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe,
    output logic [PTR_W-1:0]     reg_addr,
    output logic                 reg_wr_en,
    output logic [BYTE_W-1:0]    reg_wdata,
    output logic                 reg_rd_en,
    input  logic [BYTE_W-1:0]    reg_rdata
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    // ---------------------------------------------------------------
    // Line conditioning
    // ---------------------------------------------------------------
    logic [1:0] lines_s;
    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;

    i2cr_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    i2cr_linecond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // ---------------------------------------------------------------
    // Controller state
    // ---------------------------------------------------------------
    i2cr_state_e           state_q;
    i2cr_state_e           state_d;
    i2cr_state_e           after_q;
    logic [CNT_W-1:0]      bit_cnt_q;
    logic [BYTE_W-1:0]     rx_q;
    logic [BYTE_W-1:0]     tx_q;
    logic [PTR_W-1:0]      ptr_q;
    logic                  slot_q;
    logic                  rd_pend_q;

    logic [BYTE_W-1:0]     rx_byte;
    logic                  byte_done;
    logic                  addr_hit;

    assign rx_byte   = {rx_q[BYTE_W-2:0], sda_s};
    assign byte_done = scl_rise && (bit_cnt_q == LAST_BIT);
    assign addr_hit  = (rx_byte[BYTE_W-1:1] == DEV_ADDR);

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_DEVADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_DEVADDR: if (byte_done) state_d = addr_hit ? ST_ACK : ST_IGNORE;
                ST_PTRHI,
                ST_PTRLO,
                ST_WRDATA:  if (byte_done) state_d = ST_ACK;
                ST_ACK:     if (scl_fall && slot_q) state_d = after_q;
                ST_RDDATA:  if (byte_done) state_d = ST_RDACK;
                ST_RDACK: begin
                    if (scl_rise && sda_s)        state_d = ST_IDLE;
                    else if (scl_fall && slot_q)  state_d = ST_RDDATA;
                end
                ST_IGNORE:  state_d = ST_IGNORE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            after_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            ptr_q     <= '0;
            slot_q    <= 1'b0;
            rd_pend_q <= 1'b0;
            sda_oe    <= 1'b0;
            reg_addr  <= '0;
            reg_wr_en <= 1'b0;
            reg_wdata <= '0;
            reg_rd_en <= 1'b0;
        end else begin
            reg_wr_en <= 1'b0;
            reg_rd_en <= 1'b0;
            rd_pend_q <= reg_rd_en;
            if (rd_pend_q) tx_q <= reg_rdata;

            if (start_det || stop_det) begin
                sda_oe    <= 1'b0;
                bit_cnt_q <= '0;
                slot_q    <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_DEVADDR, ST_PTRHI, ST_PTRLO, ST_WRDATA: begin
                        if (scl_rise) begin
                            rx_q      <= rx_byte;
                            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        end
                        if (byte_done) begin
                            bit_cnt_q <= '0;
                            slot_q    <= 1'b0;
                            unique case (state_q)
                                ST_DEVADDR: begin
                                    after_q <= rx_byte[0] ? ST_RDDATA : ST_PTRHI;
                                    if (addr_hit && rx_byte[0]) begin
                                        reg_rd_en <= 1'b1;
                                        reg_addr  <= ptr_q;
                                    end
                                end
                                ST_PTRHI: begin
                                    ptr_q[PTR_W-1:BYTE_W] <= rx_byte;
                                    after_q               <= ST_PTRLO;
                                end
                                ST_PTRLO: begin
                                    ptr_q[BYTE_W-1:0] <= rx_byte;
                                    after_q           <= ST_WRDATA;
                                end
                                default: begin
                                    reg_wr_en <= 1'b1;
                                    reg_addr  <= ptr_q;
                                    reg_wdata <= rx_byte;
                                    ptr_q     <= ptr_q + PTR_W'(1);
                                    after_q   <= ST_WRDATA;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (!slot_q) begin
                                sda_oe <= 1'b1;
                                slot_q <= 1'b1;
                            end else begin
                                slot_q    <= 1'b0;
                                bit_cnt_q <= '0;
                                sda_oe    <= (after_q == ST_RDDATA) ? !tx_q[BYTE_W-1] : 1'b0;
                            end
                        end
                    end
                    ST_RDDATA: begin
                        if (scl_rise) bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                        if (byte_done) begin
                            bit_cnt_q <= '0;
                            slot_q    <= 1'b0;
                            ptr_q     <= ptr_q + PTR_W'(1);
                        end else if (scl_fall) begin
                            sda_oe <= !tx_q[BYTE_W-2];
                            tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_RDACK: begin
                        if (scl_fall && !slot_q) begin
                            sda_oe <= 1'b0;
                        end else if (scl_fall && slot_q) begin
                            slot_q    <= 1'b0;
                            bit_cnt_q <= '0;
                            sda_oe    <= !tx_q[BYTE_W-1];
                        end
                        if (scl_rise && !sda_s) begin
                            slot_q    <= 1'b1;
                            reg_rd_en <= 1'b1;
                            reg_addr  <= ptr_q;
                        end
                    end
                    ST_IDLE, ST_IGNORE: sda_oe <= 1'b0;
                    default:            sda_oe <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cr_checker.sv
module i2cr_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic reg_wr_en,
    input logic reg_rd_en
);

    // R10: the data driver moves only while the bus clock is low
    a_r10_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R12: write strobe lasts one cycle
    a_r12_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R12: read strobe lasts one cycle
    a_r12_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);

    // R12: read and write strobes never coincide
    a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    // R4: a register write happens on the eighth bit, never during the acknowledge drive
    a_r4_wr_not_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> !sda_oe);

endmodule

bind i2c_regport i2cr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en)
);

// File: tb/i2c_regport_bench.sv
`timescale 1ns/1ps
module i2c_regport_bench;

    localparam logic [6:0] DEV = 7'h4A;
    localparam int Q = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe;
    logic [15:0] reg_addr;
    logic        reg_wr_en;
    logic [7:0]  reg_wdata;
    logic        reg_rd_en;
    logic [7:0]  reg_rdata = 8'h00;
    logic        sda_bus;

    int n_cmp = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int r10_bad = 0;
    int r12_bad = 0;
    logic oe_prev = 1'b0;
    logic scl_prev = 1'b1;
    logic wr_prev = 1'b0;
    logic rd_prev = 1'b0;
    bit   done = 1'b0;

    logic [7:0] mem [bit [15:0]];

    always #2.5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    i2c_regport #(.DEV_ADDR(DEV)) u_i2c_regport (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rd_en (reg_rd_en),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [7:0] mget(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    // register bank model: data valid the cycle after the read strobe
    always @(posedge clk) begin
        if (reg_wr_en) begin
            mem[reg_addr] = reg_wdata;
            wr_cnt++;
        end
        if (reg_rd_en) begin
            reg_rdata <= mget(reg_addr);
            rd_cnt++;
        end
    end

    // monitors for R10 and R12
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_oe !== oe_prev && m_scl && scl_prev) r10_bad++;
            if ((reg_wr_en && wr_prev) || (reg_rd_en && rd_prev) || (reg_wr_en && reg_rd_en)) r12_bad++;
        end
        oe_prev  = sda_oe;
        scl_prev = m_scl;
        wr_prev  = reg_wr_en;
        rd_prev  = reg_rd_en;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qwait;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; qwait;
        m_scl = 1'b1; qwait;
        m_sda = 1'b0; qwait;
        m_scl = 1'b0; qwait;
    endtask

    task automatic bus_stop;
        qwait; m_sda = 1'b0;
        qwait; m_scl = 1'b1;
        qwait; m_sda = 1'b1;
        qwait;
    endtask

    task automatic send_bit(input logic b);
        qwait; m_sda = b;
        qwait; m_scl = 1'b1;
        qwait; qwait; m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        qwait; m_sda = 1'b1;
        qwait; m_scl = 1'b1;
        qwait; ack = ~sda_bus;
        qwait; m_scl = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        d = '0;
        for (int i = 0; i < 8; i++) begin
            qwait; m_sda = 1'b1;
            qwait; m_scl = 1'b1;
            qwait; d = {d[6:0], sda_bus};
            qwait; m_scl = 1'b0;
        end
        qwait; m_sda = ~give_ack;
        qwait; m_scl = 1'b1;
        qwait; qwait; m_scl = 1'b0;
    endtask

    task automatic open_write(input logic [15:0] p, input string req);
        logic ack;
        bus_start;
        send_byte({DEV, 1'b0}, ack); chk({req, " addr ack"}, ack, 1'b1);
        send_byte(p[15:8], ack);     chk({req, " ptr hi ack"}, ack, 1'b1);
        send_byte(p[7:0], ack);      chk({req, " ptr lo ack"}, ack, 1'b1);
    endtask

    task automatic open_read(input string req);
        logic ack;
        bus_start;
        send_byte({DEV, 1'b1}, ack); chk({req, " read addr ack"}, ack, 1'b1);
    endtask

    task automatic t_reset;
        chk("R1 sda_oe after reset", sda_oe, 1'b0);
        chk("R1 no strobes after reset", wr_cnt + rd_cnt, 0);
    endtask

    task automatic t_write_basic;
        logic ack;
        int w0 = wr_cnt;
        open_write(16'h1234, "R2/R4");
        send_byte(8'hA1, ack); chk("R4 data ack", ack, 1'b1);
        send_byte(8'hB2, ack); chk("R4 data ack", ack, 1'b1);
        send_byte(8'hC3, ack); chk("R4 data ack", ack, 1'b1);
        bus_stop;
        chk("R4 mem 1234", mget(16'h1234), 8'hA1);
        chk("R4 mem 1235", mget(16'h1235), 8'hB2);
        chk("R4 mem 1236", mget(16'h1236), 8'hC3);
        chk("R12 write strobes", wr_cnt - w0, 3);
    endtask

    task automatic t_read_after_ptr;
        logic [7:0] d;
        int r0;
        open_write(16'h1234, "R9");
        open_read("R9");
        r0 = rd_cnt - 1;
        recv_byte(1'b1, d); chk("R5 read byte0", d, 8'hA1);
        recv_byte(1'b1, d); chk("R5 read byte1", d, 8'hB2);
        recv_byte(1'b0, d); chk("R5 read byte2", d, 8'hC3);
        qwait; qwait;
        chk("R7 released after nack", sda_oe, 1'b0);
        chk("R7 fetch count", rd_cnt - r0, 3);
        bus_stop;
    endtask

    task automatic t_mismatch;
        logic ack;
        int   acks = 0;
        int   w0 = wr_cnt;
        int   r0 = rd_cnt;
        bus_start;
        send_byte({DEV ^ 7'h01, 1'b0}, ack); chk("R3 no ack on mismatch", ack, 1'b0);
        send_byte(8'h00, ack); acks += ack;
        send_byte(8'h10, ack); acks += ack;
        send_byte(8'h55, ack); acks += ack;
        chk("R3 silent after mismatch", acks, 0);
        chk("R3 no register access", (wr_cnt - w0) + (rd_cnt - r0), 0);
        bus_start;
        send_byte({DEV, 1'b0}, ack); chk("R3 answers after new START", ack, 1'b1);
        bus_stop;
    endtask

    task automatic t_partial;
        logic [7:0] d;
        logic ack;
        int w0;
        mem[16'h2001] = 8'h5A;
        w0 = wr_cnt;
        open_write(16'h2000, "R8");
        send_byte(8'h11, ack); chk("R8 full byte ack", ack, 1'b1);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop;
        chk("R8 full byte written", mget(16'h2000), 8'h11);
        chk("R8 partial byte dropped at STOP", mget(16'h2001), 8'h5A);
        chk("R8 one strobe only", wr_cnt - w0, 1);
        open_write(16'h2001, "R8");
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        open_read("R9 repeated START mid byte");
        recv_byte(1'b0, d);
        chk("R8 pointer kept after START mid byte", d, 8'h5A);
        bus_stop;
        chk("R8 partial byte dropped at START", mget(16'h2001), 8'h5A);
    endtask

    task automatic t_wrap;
        logic [7:0] d;
        logic ack;
        open_write(16'hFFFE, "R6");
        send_byte(8'h61, ack);
        send_byte(8'h62, ack);
        send_byte(8'h63, ack); chk("R6 ack across wrap", ack, 1'b1);
        bus_stop;
        chk("R6 mem FFFE", mget(16'hFFFE), 8'h61);
        chk("R6 mem FFFF", mget(16'hFFFF), 8'h62);
        chk("R6 write wraps to 0000", mget(16'h0000), 8'h63);
        open_write(16'hFFFF, "R6");
        open_read("R6");
        recv_byte(1'b1, d); chk("R6 read FFFF", d, 8'h62);
        recv_byte(1'b0, d); chk("R6 read wraps to 0000", d, 8'h63);
        bus_stop;
    endtask

    task automatic t_burst;
        logic [7:0] d;
        logic ack;
        int   nacks = 0;
        int   errs = 0;
        open_write(16'h0100, "R11");
        for (int i = 0; i < 24; i++) begin
            send_byte(8'(i * 7 + 3), ack);
            nacks += (ack ? 0 : 1);
        end
        chk("R11 burst all acked", nacks, 0);
        open_write(16'h0100, "R11");
        open_read("R11");
        for (int i = 0; i < 24; i++) begin
            recv_byte(i != 23, d);
            if (d !== 8'(i * 7 + 3)) errs++;
            if (mget(16'(16'h0100 + i)) !== 8'(i * 7 + 3)) errs++;
        end
        bus_stop;
        chk("R11 burst readback", errs, 0);
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_write_basic;
        t_read_after_ptr;
        t_mismatch;
        t_partial;
        t_wrap;
        t_burst;
        chk("R10 drive changes only with clock low", r10_bad, 0);
        chk("R12 strobes single and exclusive", r12_bad, 0);
        done = 1'b1;
        report;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            report;
        end
    end

endmodule